// File: doc/BRIEF.md
# Clock Stop-Preset-Restart Sequencer

This block brings a free-running local digital clock into step with a broadcast time code. It does not add a correction to the counters. It stops them on the leading edge of the 01 code second, presets them, and lets them run again on the leading edge of the 02 code second. An upstream detector supplies a strobe when it recognises the long minute marker. The block then waits out a blocking interval and accepts exactly one code edge, which is the 01 second. At that edge it freezes the counter clock gate and fires a display trigger, so that the frozen reading shows the clock error.

A fixed hold interval after the 01 edge, the block pulses a strobe that presets the seconds decades to 02 and clears the sub-second decades. In the same cycle it may pulse a unit-minute advance. The advance is needed when the local clock is slow by between one and thirty seconds, because its minute count is then still one behind. The block learns this from the local clock's own minute carry. A carry seen while armed and before the 01 edge means the minute is already right, so the advance is suppressed. A manual preset of the higher decades also suppresses it and stops the clock.

The counters, the display and the marker detector lie outside the block. All timing is counted in ticks of a 1 ms enable, with the intervals set by parameters.

Top module: `clkSyncSeq`

## Requirements
- R1: After reset the state output is IDLE (code 0), the clock-gate enable is 1 and every output strobe is 0. While `arm` is 0, a marker strobe leaves the state at IDLE.
- R2: While armed in IDLE, a marker strobe moves the state to BLOCK (code 1). Code edges are ignored during BLOCK. The state becomes WAIT01 (code 2) on the BLOCK_MS-th ms tick and not earlier.
- R3: In WAIT01, a code edge moves the state to HOLD (code 3), drops the clock-gate enable to 0 and raises the display trigger for exactly one cycle.
- R4: Code edges arriving in HOLD change neither the state nor the clock-gate enable. On the HOLD_MS-th ms tick in HOLD, the seconds-preset and sub-second-clear strobes pulse together for one cycle and the state becomes WAIT02 (code 4).
- R5: The unit-minute advance strobe pulses only in the cycle of the seconds-preset strobe. It pulses only when the advance flag is still set; a rising edge of `arm` sets that flag.
- R6: A minute-carry strobe received while armed in IDLE, BLOCK or WAIT01 clears the advance flag. A carry received in HOLD leaves the flag as it was.
- R7: A manual-preset strobe received while armed drops the clock-gate enable to 0 in the next cycle and clears the advance flag.
- R8: In WAIT02, a code edge raises the clock-gate enable and moves the state to RUN (code 5). RUN ignores marker strobes and code edges until the block is disarmed.
- R9: Deasserting `arm` in any state returns the state to IDLE and sets the clock-gate enable to 1 one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Arms the sequencer; low forces IDLE |
| msTick | input | 1 | One-cycle 1 ms enable |
| markerStb | input | 1 | Minute marker detected |
| codeEdgeStb | input | 1 | Rising edge of a code second pulse |
| minCarryStb | input | 1 | Minute carry from the local clock |
| manPresetStb | input | 1 | Manual preset of the higher decades |
| clkGateEn | output | 1 | Enables the counter clock |
| dispTrig | output | 1 | Display trigger pulse at the 01 edge |
| presetSecStb | output | 1 | Preset seconds decades to 02 |
| clearSubStb | output | 1 | Clear sub-second decades |
| minAdvStb | output | 1 | Advance unit-of-minutes count by one |
| seqState | output | 3 | Current sequence state code |

## Verification
The assertions check on every cycle the relations between state and outputs. The gate stays closed throughout HOLD, no edge taken in BLOCK can jump straight to HOLD, a disarm always lands in IDLE, a minute advance only comes with a seconds preset, and a reopened gate while armed means RUN. Only the bench's scenarios can show whether the advance decision is right. It does this by sweeping where the minute carry or a manual preset falls relative to the 01 edge. It also checks the exact tick counts of both intervals and that extra code edges are ignored in each waiting state.

// File: rtl/clk_sync_pkg.sv
package clk_sync_pkg;

  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_BLOCK  = 3'd1,
    S_WAIT01 = 3'd2,
    S_HOLD   = 3'd3,
    S_WAIT02 = 3'd4,
    S_RUN    = 3'd5
  } seqState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadBlock;  // start the blocking interval
    logic loadHold;   // start the hold interval
    logic stop01;     // 01 edge accepted
    logic fire990;    // hold interval expired
    logic start02;    // 02 edge accepted
    logic carryWin;   // a minute carry now counts as "before 01"
  } seqStb_t;

endpackage

// File: rtl/clkSyncCtrl.sv
module clkSyncCtrl
  import clk_sync_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      arm,
  input  logic      markerStb,
  input  logic      codeEdgeStb,
  input  logic      cntDone,
  output seqStb_t   stb,
  output seqState_e state
);

  seqState_e nextState;

  always_comb begin
    nextState    = state;
    stb          = '0;
    stb.carryWin = arm && (state == S_IDLE || state == S_BLOCK || state == S_WAIT01);
    if (!arm) begin
      nextState = S_IDLE;
    end else begin
      case (state)
        S_IDLE:   if (markerStb) begin
                    stb.loadBlock = 1'b1;
                    nextState     = S_BLOCK;
                  end
        S_BLOCK:  if (cntDone) nextState = S_WAIT01;
        S_WAIT01: if (codeEdgeStb) begin
                    stb.stop01   = 1'b1;
                    stb.loadHold = 1'b1;
                    nextState    = S_HOLD;
                  end
        S_HOLD:   if (cntDone) begin
                    stb.fire990 = 1'b1;
                    nextState   = S_WAIT02;
                  end
        S_WAIT02: if (codeEdgeStb) begin
                    stb.start02 = 1'b1;
                    nextState   = S_RUN;
                  end
        S_RUN:    nextState = S_RUN;
        default:  nextState = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  // R2: an edge seen during BLOCK never leads straight to HOLD
  a_r2_no_skip_block: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_BLOCK) |=> (state != S_HOLD));

  // R9: disarm always lands in IDLE
  a_r9_disarm_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!arm) |=> (state == S_IDLE));

endmodule

// File: rtl/clkSyncPath.sv
module clkSyncPath
  import clk_sync_pkg::*;
#(
  parameter int BLOCK_MS = 590,
  parameter int HOLD_MS  = 990
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    arm,
  input  logic    msTick,
  input  logic    minCarryStb,
  input  logic    manPresetStb,
  input  seqStb_t stb,
  output logic    cntDone,
  output logic    clkGateEn,
  output logic    dispTrig,
  output logic    presetSecStb,
  output logic    clearSubStb,
  output logic    minAdvStb
);

  localparam int MAX_MS = (BLOCK_MS > HOLD_MS) ? BLOCK_MS : HOLD_MS;
  localparam int CW     = $clog2(MAX_MS + 1);
  localparam logic [CW-1:0] BLOCK_LD = CW'(BLOCK_MS);
  localparam logic [CW-1:0] HOLD_LD  = CW'(HOLD_MS);

  logic [CW-1:0] msCnt;
  logic          armQ;
  logic          advFlag;

  assign cntDone = msTick && (msCnt == CW'(1));

  always_ff @(posedge clk) begin
    if (!rstN)              msCnt <= '0;
    else if (stb.loadBlock) msCnt <= BLOCK_LD;
    else if (stb.loadHold)  msCnt <= HOLD_LD;
    else if (msTick && msCnt != '0) msCnt <= msCnt - CW'(1);
  end

  // Minute-advance flag: set on arming, cleared by an early carry or a manual preset
  always_ff @(posedge clk) begin
    if (!rstN) begin
      armQ    <= 1'b0;
      advFlag <= 1'b0;
    end else begin
      armQ <= arm;
      if (arm && !armQ)
        advFlag <= 1'b1;
      else if ((stb.carryWin && minCarryStb) || (arm && manPresetStb))
        advFlag <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                               clkGateEn <= 1'b1;
    else if (!arm)                           clkGateEn <= 1'b1;
    else if (stb.stop01 || manPresetStb)     clkGateEn <= 1'b0;
    else if (stb.start02)                    clkGateEn <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dispTrig     <= 1'b0;
      presetSecStb <= 1'b0;
      clearSubStb  <= 1'b0;
      minAdvStb    <= 1'b0;
    end else begin
      dispTrig     <= stb.stop01;
      presetSecStb <= stb.fire990;
      clearSubStb  <= stb.fire990;
      minAdvStb    <= stb.fire990 && advFlag;
    end
  end

  // R5: a minute advance never comes without a seconds preset
  a_r5_adv_with_preset: assert property (@(posedge clk) disable iff (!rstN)
    minAdvStb |-> presetSecStb);

  // R3: the display trigger is a single-cycle pulse
  a_r3_disp_single: assert property (@(posedge clk) disable iff (!rstN)
    dispTrig |=> !dispTrig);

endmodule

// File: rtl/clkSyncSeq.sv
module clkSyncSeq
  import clk_sync_pkg::*;
#(
  parameter int BLOCK_MS = 590,
  parameter int HOLD_MS  = 990
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       arm,
  input  logic       msTick,
  input  logic       markerStb,
  input  logic       codeEdgeStb,
  input  logic       minCarryStb,
  input  logic       manPresetStb,
  output logic       clkGateEn,
  output logic       dispTrig,
  output logic       presetSecStb,
  output logic       clearSubStb,
  output logic       minAdvStb,
  output logic [2:0] seqState
);

  seqStb_t   stb;
  seqState_e state;
  logic      cntDone;

  clkSyncCtrl ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .arm         (arm),
    .markerStb   (markerStb),
    .codeEdgeStb (codeEdgeStb),
    .cntDone     (cntDone),
    .stb         (stb),
    .state       (state)
  );

  clkSyncPath #(
    .BLOCK_MS (BLOCK_MS),
    .HOLD_MS  (HOLD_MS)
  ) path_i (
    .clk          (clk),
    .rstN         (rstN),
    .arm          (arm),
    .msTick       (msTick),
    .minCarryStb  (minCarryStb),
    .manPresetStb (manPresetStb),
    .stb          (stb),
    .cntDone      (cntDone),
    .clkGateEn    (clkGateEn),
    .dispTrig     (dispTrig),
    .presetSecStb (presetSecStb),
    .clearSubStb  (clearSubStb),
    .minAdvStb    (minAdvStb)
  );

  assign seqState = state;

  // R4: the counters stay stopped for the whole hold interval
  a_r4_stopped_in_hold: assert property (@(posedge clk) disable iff (!rstN)
    (seqState == 3'd3) |-> !clkGateEn);

  // R8: while armed, the gate only reopens on entry to RUN
  a_r8_reopen_run: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(clkGateEn) && $past(arm)) |-> (seqState == 3'd5));

endmodule

// File: tb/clkSyncSeq_tb_top.sv
module clkSyncSeq_tb_top;

  localparam int BLK  = 4;
  localparam int HOLD = 6;

  logic clk = 1'b0;
  logic rstN, arm, msTick, markerStb, codeEdgeStb, minCarryStb, manPresetStb;
  logic clkGateEn, dispTrig, presetSecStb, clearSubStb, minAdvStb;
  logic [2:0] seqState;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  clkSyncSeq #(.BLOCK_MS(BLK), .HOLD_MS(HOLD)) dut_i (
    .clk(clk), .rstN(rstN), .arm(arm), .msTick(msTick), .markerStb(markerStb),
    .codeEdgeStb(codeEdgeStb), .minCarryStb(minCarryStb), .manPresetStb(manPresetStb),
    .clkGateEn(clkGateEn), .dispTrig(dispTrig), .presetSecStb(presetSecStb),
    .clearSubStb(clearSubStb), .minAdvStb(minAdvStb), .seqState(seqState)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive one cycle of inputs from a falling edge; return at the next falling edge
  task automatic cyc(input bit t, input bit mk, input bit ce, input bit cy, input bit mp);
    msTick = t; markerStb = mk; codeEdgeStb = ce; minCarryStb = cy; manPresetStb = mp;
    @(negedge clk);
    msTick = 0; markerStb = 0; codeEdgeStb = 0; minCarryStb = 0; manPresetStb = 0;
  endtask

  // c: 0 none, 1 carry armed in IDLE, 2 carry in BLOCK, 3 carry in WAIT01,
  //    4 carry in HOLD, 5 manual preset in BLOCK
  task automatic runSeq(input int c);
    bit expAdv;
    expAdv = (c == 0 || c == 4);
    arm = 0; cyc(0,0,0,0,0);
    arm = 1; cyc(0,0,0,0,0);
    if (c == 1) cyc(0,0,0,1,0);
    cyc(0,1,0,0,0);
    chk($sformatf("R2 enter BLOCK c%0d", c), seqState, 1);
    if (c == 2) cyc(0,0,0,1,0);
    if (c == 5) begin
      cyc(0,0,0,0,1);
      chk($sformatf("R7 manual stops gate c%0d", c), clkGateEn, 0);
    end
    cyc(0,0,1,0,0);
    chk($sformatf("R2 edge ignored in BLOCK c%0d", c), seqState, 1);
    for (int i = 0; i < BLK - 1; i++) cyc(1,0,0,0,0);
    chk($sformatf("R2 still BLOCK c%0d", c), seqState, 1);
    cyc(1,0,0,0,0);
    chk($sformatf("R2 WAIT01 after ticks c%0d", c), seqState, 2);
    if (c == 3) cyc(0,0,0,1,0);
    cyc(0,0,1,0,0);
    chk($sformatf("R3 HOLD c%0d", c), seqState, 3);
    chk($sformatf("R3 gate closed c%0d", c), clkGateEn, 0);
    chk($sformatf("R3 display trigger c%0d", c), dispTrig, 1);
    cyc(0,0,0,0,0);
    chk($sformatf("R3 trigger one cycle c%0d", c), dispTrig, 0);
    cyc(0,0,1,0,0);
    chk($sformatf("R4 edge ignored in HOLD c%0d", c), seqState, 3);
    chk($sformatf("R4 gate stays closed c%0d", c), clkGateEn, 0);
    if (c == 4) cyc(0,0,0,1,0);
    for (int i = 0; i < HOLD - 1; i++) cyc(1,0,0,0,0);
    chk($sformatf("R4 no early preset c%0d", c), presetSecStb, 0);
    cyc(1,0,0,0,0);
    chk($sformatf("R4 preset seconds c%0d", c), presetSecStb, 1);
    chk($sformatf("R4 clear sub-second c%0d", c), clearSubStb, 1);
    chk($sformatf("R5 R6 minute advance c%0d", c), minAdvStb, expAdv);
    chk($sformatf("R4 WAIT02 c%0d", c), seqState, 4);
    cyc(0,0,0,0,0);
    chk($sformatf("R4 preset one cycle c%0d", c), presetSecStb, 0);
    chk($sformatf("R5 advance one cycle c%0d", c), minAdvStb, 0);
    cyc(0,0,1,0,0);
    chk($sformatf("R8 gate reopened c%0d", c), clkGateEn, 1);
    chk($sformatf("R8 RUN c%0d", c), seqState, 5);
    cyc(0,1,1,0,0);
    chk($sformatf("R8 RUN holds c%0d", c), seqState, 5);
    arm = 0; cyc(0,0,0,0,0);
    chk($sformatf("R9 disarm IDLE c%0d", c), seqState, 0);
  endtask

  initial begin
    rstN = 0; arm = 0;
    msTick = 0; markerStb = 0; codeEdgeStb = 0; minCarryStb = 0; manPresetStb = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R1 reset state", seqState, 0);
    chk("R1 reset gate", clkGateEn, 1);
    chk("R1 reset strobes", {dispTrig, presetSecStb, clearSubStb, minAdvStb}, 0);
    cyc(0,1,0,0,0);
    chk("R1 marker ignored disarmed", seqState, 0);

    for (int c = 0; c < 6; c++) runSeq(c);

    // Disarm in HOLD restores the running clock
    arm = 1; cyc(0,0,0,0,0);
    cyc(0,1,0,0,0);
    for (int i = 0; i < BLK; i++) cyc(1,0,0,0,0);
    cyc(0,0,1,0,0);
    chk("R3 HOLD before disarm", seqState, 3);
    arm = 0; cyc(0,0,0,0,0);
    chk("R9 disarm from HOLD state", seqState, 0);
    chk("R9 disarm from HOLD gate", clkGateEn, 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule